// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block takes bytes from a host bus and sends them out, one bit at a time, on a single serial line. The host writes a byte into a holding stage. Whenever the shift stage is free, or is about to finish its last bit, the byte moves across. The holding stage is then free again for the next byte. The host sees two flags. One says the holding stage can take a byte. The other says the shift stage has nothing left to send.

The line runs in one of two modes.

- **Framed (asynchronous) mode:** each character gets a low start bit in front and one or two high stop bits behind. Each bit lasts 1, 16 or 64 enabled transmit-clock cycles.
- **Clocked (synchronous) mode:** only the data bits and an optional parity bit are sent, one bit per enabled transmit-clock cycle.

The host picks the mode, the parity and the stop count through a mode register. It reaches that register with an active-low chip select, a command/data select line and active-low read and write strobes.

Top module: `dbuf_serial_tx`

## Requirements
- R1: A write is taken only on the first cycle in which `cs_n` and `wr_n` are both low after at least one cycle without that condition. A strobe held low for several cycles writes once. With `cmd_sel`=1 the write goes to the mode register; with `cmd_sel`=0 it goes to the holding stage.
- R2: `tx_ready` is 1 while the holding stage is empty. It drops in the cycle after a data write is taken.
- R3: `tx_empty` is 1 exactly while the shift stage holds no character. While it is 1, `txd` is 1.
- R4: A held byte moves into the shift stage on the clock edge where the shift stage is idle, or where it completes its final bit. Consecutive characters therefore leave no idle gap on the line.
- R5: In framed mode a character is sent in this order: a 0 start bit, then the 8 data bits least significant first, then the parity bit if enabled, then a 1 stop bit, then a second 1 stop bit if mode bit 4 is set. The idle line is 1.
- R6: In clocked mode a character is only its 8 data bits, least significant first, followed by the parity bit if enabled. There are no start or stop bits.
- R7: Mode bits [1:0] select the format:
  - 00: clocked mode, 1 cycle per bit;
  - 01: framed mode, 1 cycle per bit;
  - 10: framed mode, 16 cycles per bit;
  - 11: framed mode, 64 cycles per bit.
  
  A cycle counts only when `tx_clk_en` is 1.
- R8: Mode bit 2 enables parity. Mode bit 3 selects even parity (1) or odd parity (0). With even parity the data bits plus the parity bit contain an even number of ones; with odd parity, an odd number.
- R9: A data write while `tx_ready` is 0 is ignored. The held byte is kept and sent unchanged, and the ignored byte never appears on `txd`.
- R10: While `cs_n`, `rd_n` and `cmd_sel` are 0, 0 and 1, `dout` shows status: bit 0 is `tx_ready`, bit 1 is `tx_empty`, and all other bits are 0. In every other case `dout` is 0.
- R11: While `rst` is high and on the first cycle after it, `txd`, `tx_ready` and `tx_empty` are all 1. The mode register clears to 0.
- R12: The mode register value is sampled when a character enters the shift stage. A mode write while a character is in flight affects only later characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| cmd_sel | input | 1 | 1 selects mode/status, 0 selects data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Host write data |
| dout | output | DATA_W | Host read data (status) |
| tx_clk_en | input | 1 | Transmit clock enable, one bit-time step per high cycle |
| txd | output | 1 | Serial output line |
| tx_ready | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Shift stage empty |

## Verification
The bench keeps a behavioural queue model of the line and compares `txd` and both flags on every clock, across clocked and framed modes, all three divide settings, both parity senses and both stop counts, with `tx_clk_en` both held high and gated by a pseudo-random pattern. It attacks the handover between characters. A design that reloads one cycle late would show a stray idle bit between back-to-back clocked characters. It also issues a write into a full holding stage. A design that overwrote it would send the third byte in place of the second. A held write strobe that a level-sensitive decode would take repeatedly is also exercised, along with start-bit widths that expose a divider off by one.

// File: rtl/dbst_pkg.sv
package dbst_pkg;

   typedef enum logic [1:0] {
      DIV_SYNC = 2'b00,
      DIV_X1   = 2'b01,
      DIV_X16  = 2'b10,
      DIV_X64  = 2'b11
   } div_sel_e;

   // Mode register layout, MSB first: bit4 two stops, bit3 even parity,
   // bit2 parity enable, bits1:0 divide/format select.
   typedef struct packed {
      logic     stop2;
      logic     par_even;
      logic     par_en;
      div_sel_e div;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/dbst_bus_port.sv
module dbst_bus_port
   import dbst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              cmd_sel,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ready_i,
   input  logic              empty_i,
   output logic [DATA_W-1:0] dout,
   output mode_t             mode_o,
   output logic              data_wr_o
);

   logic  wr_act;
   logic  wr_prev_q;
   logic  wr_pulse;
   logic  rd_status;
   mode_t mode_q;

   assign wr_act   = !cs_n && !wr_n;
   assign wr_pulse = wr_act && !wr_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_prev_q <= 1'b0;
         mode_q    <= mode_t'('0);
      end else begin
         wr_prev_q <= wr_act;
         if (wr_pulse && cmd_sel)
            mode_q <= mode_t'(din[MODE_W-1:0]);
      end
   end

   assign data_wr_o = wr_pulse && !cmd_sel;
   assign mode_o    = mode_q;

   assign rd_status = !cs_n && !rd_n && cmd_sel;

   always_comb begin
      dout = '0;
      if (rd_status) begin
         dout[0] = ready_i;
         dout[1] = empty_i;
      end
   end

endmodule

// File: rtl/dbst_hold.sv
module dbst_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              take_i,
   output logic              full_o,
   output logic [DATA_W-1:0] data_o
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (take_i) begin
         full_q <= 1'b0;
      end else if (wr_i && !full_q) begin
         full_q <= 1'b1;
         data_q <= data_i;
      end
   end

   assign full_o = full_q;
   assign data_o = data_q;

endmodule

// File: rtl/dbst_bit_timer.sv
module dbst_bit_timer
   import dbst_pkg::*;
#(
   parameter int DIV_MID = 16,
   parameter int DIV_HI  = 64
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     load_i,
   input  logic     busy_i,
   input  logic     tick_i,
   input  div_sel_e div_sel_i,
   output logic     bit_done_o
);

   localparam int DV_W = $clog2(DIV_HI + 1);

   logic [DV_W-1:0] div_new;
   logic [DV_W-1:0] div_q;
   logic [DV_W-1:0] cnt_q;

   always_comb begin
      case (div_sel_i)
         DIV_X16: div_new = DV_W'(DIV_MID);
         DIV_X64: div_new = DV_W'(DIV_HI);
         default: div_new = DV_W'(1);
      endcase
   end

   assign bit_done_o = busy_i && tick_i && (cnt_q == div_q - DV_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         div_q <= DV_W'(1);
      end else if (load_i) begin
         cnt_q <= '0;
         div_q <= div_new;
      end else if (bit_done_o) begin
         cnt_q <= '0;
      end else if (busy_i && tick_i) begin
         cnt_q <= cnt_q + DV_W'(1);
      end
   end

endmodule

// File: rtl/dbst_shifter.sv
module dbst_shifter
   import dbst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int STOP_MAX = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              bit_done_i,
   input  logic [DATA_W-1:0] data_i,
   input  mode_t             mode_i,
   output logic              txd_o,
   output logic              busy_o,
   output logic              last_o
);

   localparam int FRAME_W = 1 + DATA_W + 1 + STOP_MAX;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   logic               two_stop;
   logic               framed;
   logic               par_bit;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   len;
   logic [FRAME_W-1:0] sh_q;
   logic [LEN_W-1:0]   left_q;
   logic               busy_q;

   generate
      if (STOP_MAX >= 2) begin : g_two_stop
         assign two_stop = mode_i.stop2;
      end else begin : g_one_stop
         assign two_stop = 1'b0;
      end
   endgenerate

   assign framed  = (mode_i.div != DIV_SYNC);
   assign par_bit = mode_i.par_even ? (^data_i) : ~(^data_i);

   // Frame assembled LSB first; unused high bits stay 1 (idle/stop level).
   always_comb begin
      frame = '1;
      len   = '0;
      if (framed) begin
         frame = frame & ~FRAME_W'(1);
         len   = LEN_W'(1);
      end
      frame = (frame & ~({FRAME_W{1'b0}} | (FRAME_W'({DATA_W{1'b1}}) << len)))
            | (FRAME_W'(data_i) << len);
      len   = len + LEN_W'(DATA_W);
      if (mode_i.par_en) begin
         frame = (frame & ~(FRAME_W'(1) << len)) | (FRAME_W'(par_bit) << len);
         len   = len + LEN_W'(1);
      end
      if (framed)
         len = len + (two_stop ? LEN_W'(2) : LEN_W'(1));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '1;
         left_q <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         sh_q   <= frame;
         left_q <= len;
         busy_q <= 1'b1;
      end else if (bit_done_i) begin
         sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
         left_q <= left_q - LEN_W'(1);
         busy_q <= (left_q != LEN_W'(1));
      end
   end

   assign last_o = bit_done_i && (left_q == LEN_W'(1));
   assign busy_o = busy_q;
   assign txd_o  = busy_q ? sh_q[0] : 1'b1;

endmodule

// File: rtl/dbuf_serial_tx.sv
module dbuf_serial_tx
   import dbst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DIV_MID  = 16,
   parameter int DIV_HI   = 64,
   parameter int STOP_MAX = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              cmd_sel,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   input  logic              tx_clk_en,
   output logic              txd,
   output logic              tx_ready,
   output logic              tx_empty
);

   generate
      if (DATA_W < MODE_W) begin : g_bad_width
         $error("DATA_W must hold the mode register");
      end
      if (DIV_MID < 2 || DIV_HI <= DIV_MID) begin : g_bad_div
         $error("divide factors must satisfy 1 < DIV_MID < DIV_HI");
      end
      if (STOP_MAX < 1 || STOP_MAX > 2) begin : g_bad_stop
         $error("STOP_MAX must be 1 or 2");
      end
   endgenerate

   mode_t             mode;
   logic              data_wr;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              load;
   logic              busy;
   logic              last;
   logic              bit_done;

   assign load     = hold_full && (!busy || last);
   assign tx_ready = !hold_full;
   assign tx_empty = !busy;

   dbst_bus_port #(.DATA_W(DATA_W)) u_bus (
      .clk       (clk),
      .rst       (rst),
      .cs_n      (cs_n),
      .cmd_sel   (cmd_sel),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .din       (din),
      .ready_i   (tx_ready),
      .empty_i   (tx_empty),
      .dout      (dout),
      .mode_o    (mode),
      .data_wr_o (data_wr)
   );

   dbst_hold #(.DATA_W(DATA_W)) u_hold (
      .clk    (clk),
      .rst    (rst),
      .wr_i   (data_wr),
      .data_i (din),
      .take_i (load),
      .full_o (hold_full),
      .data_o (hold_data)
   );

   dbst_bit_timer #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .load_i     (load),
      .busy_i     (busy),
      .tick_i     (tx_clk_en),
      .div_sel_i  (mode.div),
      .bit_done_o (bit_done)
   );

   dbst_shifter #(.DATA_W(DATA_W), .STOP_MAX(STOP_MAX)) u_shift (
      .clk        (clk),
      .rst        (rst),
      .load_i     (load),
      .bit_done_i (bit_done),
      .data_i     (hold_data),
      .mode_i     (mode),
      .txd_o      (txd),
      .busy_o     (busy),
      .last_o     (last)
   );

endmodule

// File: rtl/dbst_chk.sv
module dbst_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cs_n,
   input logic              cmd_sel,
   input logic              rd_n,
   input logic              wr_n,
   input logic [DATA_W-1:0] dout,
   input logic              txd,
   input logic              tx_ready,
   input logic              tx_empty
);

   // R11: reset forces an idle line and both flags high
   a_r11_reset_idle: assert property (@(posedge clk)
      rst |=> (txd && tx_ready && tx_empty));

   // R3: an empty shift stage leaves the line at its idle level
   a_r3_empty_line_high: assert property (@(posedge clk) disable iff (rst)
      tx_empty |-> txd);

   // R2: ready can only fall after a data write on the bus
   a_r2_ready_fall_cause: assert property (@(posedge clk) disable iff (rst)
      $fell(tx_ready) |-> $past(!cs_n && !wr_n && !cmd_sel));

   // R4: freeing the holding stage means a character entered the shifter
   a_r4_release_loads: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_ready) |-> !tx_empty);

   // R4: a full holding stage never waits on an idle shifter
   a_r4_idle_pulls_hold: assert property (@(posedge clk) disable iff (rst)
      (!tx_ready && tx_empty) |=> !tx_empty);

   // R10: the read bus is quiet unless a read is strobed
   a_r10_dout_quiet: assert property (@(posedge clk) disable iff (rst)
      (cs_n || rd_n) |-> (dout == '0));

endmodule

bind dbuf_serial_tx dbst_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cs_n     (cs_n),
   .cmd_sel  (cmd_sel),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .dout     (dout),
   .txd      (txd),
   .tx_ready (tx_ready),
   .tx_empty (tx_empty)
);

// File: tb/tb_dbuf_serial_tx.sv
module tb_dbuf_serial_tx;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1;
   logic       cmd_sel = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       tx_clk_en = 1'b1;
   logic       txd;
   logic       tx_ready;
   logic       tx_empty;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit en_gated = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   dbuf_serial_tx dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_sel(cmd_sel), .rd_n(rd_n),
      .wr_n(wr_n), .din(din), .dout(dout), .tx_clk_en(tx_clk_en),
      .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit       m_wprev, m_full, m_busy, m_cur, m_cur_sync;
   bit [7:0] m_hold;
   bit [4:0] m_mode;
   int       m_cnt, m_div;
   bit       m_q[$];
   bit       wa, pulse, done, lastb, load;

   function automatic int div_of(input bit [1:0] s);
      case (s)
         2'd2: return 16;
         2'd3: return 64;
         default: return 1;
      endcase
   endfunction

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_wprev = 0; m_full = 0; m_busy = 0; m_cur = 1; m_mode = '0;
         m_cnt = 0; m_div = 1; m_q.delete();
      end else begin
         wa    = !cs_n && !wr_n;
         pulse = wa && !m_wprev;
         m_wprev = wa;
         done  = m_busy && tx_clk_en && (m_cnt == m_div - 1);
         lastb = done && (m_q.size() == 0);
         load  = m_full && (!m_busy || lastb);
         if (load) begin
            bit framed;
            framed = (m_mode[1:0] != 2'b00);
            m_q.delete();
            if (framed) m_q.push_back(1'b0);
            for (int i = 0; i < 8; i++) m_q.push_back(m_hold[i]);
            if (m_mode[2]) m_q.push_back(m_mode[3] ? ^m_hold : ~^m_hold);
            if (framed) m_q.push_back(1'b1);
            if (framed && m_mode[4]) m_q.push_back(1'b1);
            m_cur = m_q.pop_front();
            m_cur_sync = !framed;
            m_busy = 1; m_cnt = 0; m_div = div_of(m_mode[1:0]);
         end else if (done) begin
            if (lastb) m_busy = 0;
            else m_cur = m_q.pop_front();
            m_cnt = 0;
         end else if (m_busy && tx_clk_en) begin
            m_cnt++;
         end
         if (load) m_full = 0;
         else if (pulse && !cmd_sel && !m_full) begin m_full = 1; m_hold = din; end
         if (pulse && cmd_sel) m_mode = din[4:0];
      end
   end

   always @(negedge clk) begin
      if (en_gated) begin
         lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_clk_en <= lfsr[0] | lfsr[3];
      end else begin
         tx_clk_en <= 1'b1;
      end
      if (!rst) begin
         chk(txd === (m_busy ? m_cur : 1'b1), m_cur_sync ? "R6" : "R5", "txd",
             int'(txd), int'(m_busy ? m_cur : 1'b1));
         chk(tx_ready === !m_full, "R2", "tx_ready", int'(tx_ready), int'(!m_full));
         chk(tx_empty === !m_busy, "R3", "tx_empty", int'(tx_empty), int'(!m_busy));
      end
   end

   // ---------------- stimulus helpers (called at a negedge) ----------------
   task automatic wr_reg(input bit c, input logic [7:0] d, input int hold = 1);
      cs_n = 0; cmd_sel = c; din = d; wr_n = 0;
      repeat (hold) @(negedge clk);
      cs_n = 1; wr_n = 1;
      @(negedge clk);
   endtask

   task automatic rd_reg(input bit c, output logic [7:0] v);
      cs_n = 0; cmd_sel = c; rd_n = 0;
      #1 v = dout;
      cs_n = 1; rd_n = 1;
   endtask

   task automatic wait_ready();
      while (!tx_ready) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (!(tx_ready && tx_empty)) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic cap_sync(input int n, output logic [31:0] v);
      v = '0;
      do @(negedge clk); while (tx_empty);
      for (int i = 0; i < n; i++) begin
         if (i > 0) @(negedge clk);
         v[i] = txd;
      end
   endtask

   task automatic low_width(output int n);
      n = 0;
      do @(negedge clk); while (txd);
      while (!txd) begin n++; @(negedge clk); end
   endtask

   initial begin
      logic [7:0]  s;
      logic [31:0] v;
      int          n;

      repeat (3) @(negedge clk);
      // R11: state during reset
      chk(txd && tx_ready && tx_empty, "R11", "idle during reset",
          int'({txd, tx_ready, tx_empty}), 7);
      rst = 0;
      @(negedge clk);
      rd_reg(1'b1, s);
      chk(s == 8'h03, "R10", "status after reset", s, 8'h03);
      rd_reg(1'b0, s);
      chk(s == 8'h00, "R10", "data-address read", s, 0);
      chk(dout == 8'h00, "R10", "no read strobe", dout, 0);

      // R1: write without chip select is not taken
      wr_n = 0; din = 8'h5A; @(negedge clk); wr_n = 1; @(negedge clk);
      chk(tx_ready && tx_empty, "R1", "write without cs_n", int'({tx_ready, tx_empty}), 3);

      // R6: clocked mode, no parity (mode reset value is 0)
      fork cap_sync(8, v); wr_reg(1'b0, 8'hA5); join
      chk(v[7:0] == 8'hA5, "R6", "clocked byte", v[7:0], 8'hA5);
      wait_idle();

      // R8: even parity on 0x07 gives 1
      wr_reg(1'b1, 8'h0C);
      fork cap_sync(9, v); wr_reg(1'b0, 8'h07); join
      chk(v[8:0] == 9'h107, "R8", "even parity frame", v[8:0], 9'h107);
      wait_idle();
      // R8: odd parity on 0x07 gives 0
      wr_reg(1'b1, 8'h04);
      fork cap_sync(9, v); wr_reg(1'b0, 8'h07); join
      chk(v[8:0] == 9'h007, "R8", "odd parity frame", v[8:0], 9'h007);
      wait_idle();

      // R4: back-to-back clocked characters with no gap
      wr_reg(1'b1, 8'h00);
      fork
         cap_sync(16, v);
         begin wr_reg(1'b0, 8'h3C); wait_ready(); wr_reg(1'b0, 8'hC3); end
      join
      chk(v[15:0] == 16'hC33C, "R4", "gapless pair", v[15:0], 16'hC33C);
      wait_idle();

      // R9: third write into a full holding stage is dropped
      fork
         cap_sync(16, v);
         begin
            wr_reg(1'b0, 8'h11); wait_ready(); wr_reg(1'b0, 8'h22);
            chk(!tx_ready, "R9", "holding full before extra write", tx_ready, 0);
            wr_reg(1'b0, 8'hEE);
         end
      join
      chk(v[15:0] == 16'h2211, "R9", "kept bytes", v[15:0], 16'h2211);
      repeat (12) begin
         @(negedge clk);
         chk(tx_empty && txd, "R9", "dropped byte never sent", int'({tx_empty, txd}), 3);
      end

      // R1: strobe held low four cycles sends one byte
      fork cap_sync(8, v); wr_reg(1'b0, 8'h96, 4); join
      chk(v[7:0] == 8'h96, "R1", "held strobe byte", v[7:0], 8'h96);
      repeat (12) begin
         @(negedge clk);
         chk(tx_empty, "R1", "held strobe wrote once", tx_empty, 1);
      end

      // R7: start bit widths for x16 and x64, framed x1
      wr_reg(1'b1, 8'h02);
      fork low_width(n); wr_reg(1'b0, 8'h01); join
      chk(n == 16, "R7", "x16 start width", n, 16);
      wait_idle();
      wr_reg(1'b1, 8'h17);
      fork low_width(n); wr_reg(1'b0, 8'h55); join
      chk(n == 64, "R7", "x64 start width", n, 64);
      rd_reg(1'b1, s);
      chk(s == 8'h01, "R10", "status mid character", s, 8'h01);
      // R12: mode change in flight affects only the next character
      wr_reg(1'b1, 8'h01);
      wait_idle();
      fork low_width(n); wr_reg(1'b0, 8'h01); join
      chk(n == 1, "R12", "new mode on next character", n, 1);
      wait_idle();

      // R5: framed characters with gated transmit clock, per-cycle model
      en_gated = 1'b1;
      for (int k = 0; k < 6; k++) begin
         wr_reg(1'b1, 8'((k % 2) ? 8'h1E : 8'h0A));
         for (int j = 0; j < 3; j++) begin
            wait_ready();
            wr_reg(1'b0, 8'(8'h3B * (k + 1) + j));
         end
         wait_idle();
      end
      en_gated = 1'b0;
      wait_idle();
      rd_reg(1'b1, s);
      chk(s == 8'h03, "R10", "status when idle", s, 8'h03);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      failures++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule